// File: doc/BRIEF.md
# Single-Channel Word Copy Engine

This block moves a run of 16-bit words from one place in memory to another without CPU help. Software programs it through eight 16-bit registers. A source address, a destination address and a word count are each split into a low and a high half. Writing the control word into the mode register is the act that launches a copy. No separate go bit exists.

Only one control value starts a copy. A second known value is stored and has no effect. Any other value is stored and raises a sticky error flag. A running copy reads one word and then writes it, over a single word-addressed memory master port with a ready handshake. Both addresses step by one after each word. A busy output covers the whole transfer, and register writes that arrive while it is high are dropped.

Top module: `wdma_engine`

## Requirements
- R1: Register index 0 holds the mode, 1 the source low half, 2 the destination low half, 3 the count low half, 4 the source high half, 5 the destination high half, 6 the count high half, and 7 is a spare. Each of the eight reads back on `reg_rdata` the last value written to it while the engine was idle.
- R2: Source, destination and count are 32-bit values formed as {high half, low half}. The first read address of a copy equals the full 32-bit source.
- R3: Suppose the engine is idle and the count is non-zero, and 0x4009 is written to index 0. `busy` is then high from the next cycle, and the engine moves exactly `count` words.
- R4: Word k of a copy is read from source+k and written to destination+k.
- R5: Writing 0x0200 to index 0 stores the value, starts no transfer and leaves the error flag unchanged.
- R6: Writing any value other than 0x4009 or 0x0200 to index 0 stores it and starts no transfer. It also sets `mode_err`, which stays high until reset.
- R7: If 0x4009 is written with a count of zero, `busy` stays low and no memory request is issued.
- R8: A register write accepted while `busy` is high changes no register and starts nothing. This includes a write to the mode register.
- R9: Only one memory request is outstanding at a time. A read is always followed by the write of the same word. A request holds its address, direction and write data until a cycle with `mem_ready` high. `busy` falls in the cycle after the last write is accepted.
- R10: After reset, every register reads zero and `busy`, `mem_req` and `mode_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and readback |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Readback of the register at `reg_addr` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the cycle `mem_ready` accepts a read |
| mem_ready | input | 1 | Memory accepts the current request |
| busy | output | 1 | Copy in progress |
| mode_err | output | 1 | Sticky flag for an unknown mode value |

## Verification
The bench uses the default parameters: 16-bit registers, so addresses and counts are 32 bits wide, with 0x4009 as the copy code and 0x0200 as the inert code. A 32-bit source lets the bench put a non-zero high half on the source address, so the join of the two halves shows up on the memory port. Its 4096-word memory model decodes the low twelve address bits. Small counts keep each copy short, so a randomly stalling ready, writes that land in the middle of a copy, and an overlapping forward copy all fit in one run.

// File: rtl/wdma_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the word copy engine.
// Assumes a fixed file of eight registers; index values are behaviour
// that software depends on, so they live here once.
package wdma_pkg;

    localparam int unsigned NUM_REGS  = 8;
    localparam int unsigned REG_IDX_W = $clog2(NUM_REGS);

    localparam int unsigned IDX_MODE   = 0;
    localparam int unsigned IDX_SRC_LO = 1;
    localparam int unsigned IDX_DST_LO = 2;
    localparam int unsigned IDX_CNT_LO = 3;
    localparam int unsigned IDX_SRC_HI = 4;
    localparam int unsigned IDX_DST_HI = 5;
    localparam int unsigned IDX_CNT_HI = 6;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/wdma_regfile.sv
`timescale 1ns/1ps
// Module: wdma_regfile
// Holds the eight programming registers and joins the split halves
// into full-width source, destination and count values.
// Assumes the caller has already dropped writes that must be ignored.
module wdma_regfile
    import wdma_pkg::*;
#(
    parameter int unsigned REG_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_IDX_W-1:0]  wr_idx,
    input  logic [REG_W-1:0]      wr_data,
    input  logic [REG_IDX_W-1:0]  rd_idx,
    output logic [REG_W-1:0]      rd_data,
    output logic [2*REG_W-1:0]    src_full,
    output logic [2*REG_W-1:0]    dst_full,
    output logic [2*REG_W-1:0]    cnt_full
);

    logic [REG_W-1:0] regs_q [NUM_REGS];

    // Store a write into the addressed register; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_idx == REG_IDX_W'(i)) begin
                    regs_q[i] <= wr_data;
                end
            end
        end
    end

    // Readback mux.
    always_comb begin
        rd_data = regs_q[rd_idx];
    end

    // Join high and low halves.
    always_comb begin
        src_full = {regs_q[IDX_SRC_HI], regs_q[IDX_SRC_LO]};
        dst_full = {regs_q[IDX_DST_HI], regs_q[IDX_DST_LO]};
        cnt_full = {regs_q[IDX_CNT_HI], regs_q[IDX_CNT_LO]};
    end

endmodule

// File: rtl/wdma_trigger.sv
`timescale 1ns/1ps
// Module: wdma_trigger
// Decodes writes to the mode register. The copy code with a non-zero
// count yields a one-cycle start; the inert code does nothing; any
// other code sets a sticky error flag.
// Assumes wr_en is already qualified with "not busy".
module wdma_trigger
    import wdma_pkg::*;
#(
    parameter int unsigned      REG_W     = 16,
    parameter logic [REG_W-1:0] COPY_CODE = 16'h4009,
    parameter logic [REG_W-1:0] NOP_CODE  = 16'h0200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 cnt_zero,
    output logic                 start,
    output logic                 mode_err
);

    logic mode_hit;
    logic is_copy;
    logic is_known;
    logic err_q;

    // Classify the write.
    always_comb begin
        mode_hit = wr_en && (wr_idx == REG_IDX_W'(IDX_MODE));
        is_copy  = (wr_data == COPY_CODE);
        is_known = is_copy || (wr_data == NOP_CODE);
        start    = mode_hit && is_copy && !cnt_zero;
    end

    // Sticky error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (mode_hit && !is_known) begin
            err_q <= 1'b1;
        end
    end

    assign mode_err = err_q;

endmodule

// File: rtl/wdma_sequencer.sv
`timescale 1ns/1ps
// Module: wdma_sequencer
// Runs one copy: read a word at the running source, then write it at
// the running destination, each step waiting for mem_ready; repeats
// until the count is exhausted.
// Assumes start only arrives while idle and with a non-zero count.
module wdma_sequencer
    import wdma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 16,
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [CW-1:0] cnt_i,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          busy
);

    seq_state_t    state_q;
    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;
    logic [CW-1:0] left_q;
    logic [DW-1:0] hold_q;
    logic          last_word;

    assign last_word = (left_q == CW'(1));

    // State, running addresses, remaining count and the word in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
            left_q  <= '0;
            hold_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        src_q   <= src_i;
                        dst_q   <= dst_i;
                        left_q  <= cnt_i;
                        state_q <= SEQ_READ;
                    end
                end
                SEQ_READ: begin
                    if (mem_ready) begin
                        hold_q  <= mem_rdata;
                        state_q <= SEQ_WRITE;
                    end
                end
                SEQ_WRITE: begin
                    if (mem_ready) begin
                        src_q   <= src_q + AW'(1);
                        dst_q   <= dst_q + AW'(1);
                        left_q  <= left_q - CW'(1);
                        state_q <= last_word ? SEQ_IDLE : SEQ_READ;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Drive the memory master port from the current step.
    always_comb begin
        mem_req   = (state_q != SEQ_IDLE);
        mem_we    = (state_q == SEQ_WRITE);
        mem_addr  = (state_q == SEQ_WRITE) ? dst_q : src_q;
        mem_wdata = hold_q;
        busy      = (state_q != SEQ_IDLE);
    end

endmodule

// File: rtl/wdma_engine.sv
`timescale 1ns/1ps
// Module: wdma_engine (top)
// Register-programmed single-channel word copy engine. Writes are
// dropped while a copy runs; a mode write of the copy code launches it.
// Assumes a memory slave that returns read data in the accepting cycle.
module wdma_engine
    import wdma_pkg::*;
#(
    parameter int unsigned      REG_W     = 16,
    parameter logic [REG_W-1:0] COPY_CODE = 16'h4009,
    parameter logic [REG_W-1:0] NOP_CODE  = 16'h0200
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_IDX_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [2*REG_W-1:0]    mem_addr,
    output logic [REG_W-1:0]      mem_wdata,
    input  logic [REG_W-1:0]      mem_rdata,
    input  logic                  mem_ready,
    output logic                  busy,
    output logic                  mode_err
);

    localparam int unsigned FULL_W = 2 * REG_W;

    logic              accept_wr;
    logic              start_copy;
    logic [FULL_W-1:0] src_val;
    logic [FULL_W-1:0] dst_val;
    logic [FULL_W-1:0] len_val;

    // Drop register writes while a copy is running.
    assign accept_wr = reg_wr && !busy;

    wdma_regfile #(
        .REG_W (REG_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept_wr),
        .wr_idx   (reg_addr),
        .wr_data  (reg_wdata),
        .rd_idx   (reg_addr),
        .rd_data  (reg_rdata),
        .src_full (src_val),
        .dst_full (dst_val),
        .cnt_full (len_val)
    );

    wdma_trigger #(
        .REG_W     (REG_W),
        .COPY_CODE (COPY_CODE),
        .NOP_CODE  (NOP_CODE)
    ) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept_wr),
        .wr_idx   (reg_addr),
        .wr_data  (reg_wdata),
        .cnt_zero (len_val == '0),
        .start    (start_copy),
        .mode_err (mode_err)
    );

    wdma_sequencer #(
        .AW (FULL_W),
        .DW (REG_W),
        .CW (FULL_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_copy),
        .src_i     (src_val),
        .dst_i     (dst_val),
        .cnt_i     (len_val),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .busy      (busy)
    );

endmodule

// File: rtl/wdma_checker.sv
`timescale 1ns/1ps
// Module: wdma_checker
// Protocol and sequencing properties of the copy engine, bound to the top.
// Assumes the count value seen here is the one the trigger decode uses.
module wdma_checker
    import wdma_pkg::*;
#(
    parameter int unsigned      REG_W     = 16,
    parameter logic [REG_W-1:0] COPY_CODE = 16'h4009
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [REG_IDX_W-1:0] reg_addr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic                 busy,
    input logic                 mode_err,
    input logic                 mem_req,
    input logic                 mem_we,
    input logic [2*REG_W-1:0]   mem_addr,
    input logic [REG_W-1:0]     mem_wdata,
    input logic                 mem_ready,
    input logic [2*REG_W-1:0]   len_val
);

    localparam int unsigned AW = 2 * REG_W;

    logic          rd_seen;
    logic          wr_seen;
    logic [AW-1:0] last_rd;
    logic [AW-1:0] last_wr;
    logic          mode_wr_idle;

    assign mode_wr_idle = reg_wr && !busy && (reg_addr == REG_IDX_W'(IDX_MODE));

    // Remember the last accepted read and write addresses within one copy.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            rd_seen <= 1'b0;
            wr_seen <= 1'b0;
            last_rd <= '0;
            last_wr <= '0;
        end else if (mem_req && mem_ready) begin
            if (mem_we) begin
                wr_seen <= 1'b1;
                last_wr <= mem_addr;
            end else begin
                rd_seen <= 1'b1;
                last_rd <= mem_addr;
            end
        end
    end

    a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    a_r9_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ready |=> mem_req && mem_we);

    a_r3_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_req && !mem_we);

    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_idle && reg_wdata == COPY_CODE && len_val != '0 |=> busy);

    a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_idle && reg_wdata == COPY_CODE && len_val == '0 |=> !busy);

    a_r5_other_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_idle && reg_wdata != COPY_CODE |=> !busy);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);

    a_r4_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && rd_seen |-> mem_addr == AW'(last_rd + AW'(1)));

    a_r4_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && wr_seen |-> mem_addr == AW'(last_wr + AW'(1)));

    a_r9_no_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

bind wdma_engine wdma_checker #(
    .REG_W     (REG_W),
    .COPY_CODE (COPY_CODE)
) u_wdma_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .mode_err  (mode_err),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .len_val   (len_val)
);

// File: tb/test_wdma_engine.sv
`timescale 1ns/1ps
// Bench: behavioural reference (register array, queue of pending memory
// steps) compared with the design at every falling edge, plus directed
// checks at the corners.
module test_wdma_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_ready = 1'b1;
    logic        busy;
    logic        mode_err;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit stall_mode = 1'b0;

    logic [15:0] mem    [4096];
    logic [15:0] shadow [4096];

    // reference model state
    logic [15:0] m_regs [8];
    bit          m_err;
    logic [15:0] m_data;
    int unsigned q_addr [$];
    bit          q_we   [$];

    logic [31:0] first_rd;
    logic [31:0] first_wr;
    bit          prev_req = 1'b0;

    always #2 clk = ~clk;

    wdma_engine i_wdma_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .busy      (busy),
        .mode_err  (mode_err)
    );

    assign mem_rdata = mem[mem_addr[11:0]];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Memory slave: store accepted writes.
    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ready) mem[mem_addr[11:0]] <= mem_wdata;
    end

    // Ready generator, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        mem_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin : model_blk
        bit pre_busy;
        int unsigned len;
        int unsigned a;
        pre_busy = (q_addr.size() != 0);
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_regs[i] = 16'h0;
            m_err  = 1'b0;
            m_data = 16'h0;
            q_addr.delete();
            q_we.delete();
        end else begin
            if (pre_busy && mem_ready) begin
                a = q_addr[0];
                if (!q_we[0]) m_data = mem[a % 4096];
                void'(q_addr.pop_front());
                void'(q_we.pop_front());
            end
            if (reg_wr && !pre_busy) begin
                m_regs[reg_addr] = reg_wdata;
                if (reg_addr == 3'd0) begin
                    if (reg_wdata == 16'h4009) begin
                        len = {m_regs[6], m_regs[3]};
                        for (int unsigned k = 0; k < len; k++) begin
                            q_addr.push_back({m_regs[4], m_regs[1]} + k);
                            q_we.push_back(1'b0);
                            q_addr.push_back({m_regs[5], m_regs[2]} + k);
                            q_we.push_back(1'b1);
                        end
                    end else if (reg_wdata != 16'h0200) begin
                        m_err = 1'b1;
                    end
                end
            end
        end
    end

    // Per-cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 busy", {31'd0, busy}, {31'd0, q_addr.size() != 0});
            check("R9 req", {31'd0, mem_req}, {31'd0, q_addr.size() != 0});
            if (q_addr.size() != 0 && mem_req) begin
                check("R9 dir", {31'd0, mem_we}, {31'd0, q_we[0]});
                check("R4 addr", mem_addr, q_addr[0]);
                if (q_we[0]) check("R4 wdata", {16'd0, mem_wdata}, {16'd0, m_data});
            end
            check("R6 err", {31'd0, mode_err}, {31'd0, m_err});
            check("R1 readback", {16'd0, reg_rdata}, {16'd0, m_regs[reg_addr]});
            if (mem_req && !prev_req) first_rd = mem_addr;
            if (mem_req && mem_we && !prev_req_we) first_wr = mem_addr;
        end
    end

    bit prev_req_we = 1'b0;
    always @(negedge clk) begin
        prev_req    <= mem_req;
        prev_req_we <= mem_req && mem_we ? 1'b1 : (mem_req ? prev_req_we : 1'b0);
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=60000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, input logic [15:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        check(tag, {16'd0, reg_rdata}, {16'd0, exp});
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic setup(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] len);
        reg_write(3'd1, src[15:0]);  reg_write(3'd4, src[31:16]);
        reg_write(3'd2, dst[15:0]);  reg_write(3'd5, dst[31:16]);
        reg_write(3'd3, len[15:0]);  reg_write(3'd6, len[31:16]);
    endtask

    task automatic predict(input logic [31:0] src, input logic [31:0] dst, input int len);
        for (int i = 0; i < 4096; i++) shadow[i] = mem[i];
        for (int i = 0; i < len; i++) shadow[(dst + i) % 4096] = shadow[(src + i) % 4096];
    endtask

    task automatic compare_mem(input string tag);
        for (int i = 0; i < 4096; i++) begin
            if (mem[i] !== shadow[i]) check(tag, {16'd0, mem[i]}, {16'd0, shadow[i]});
        end
        check(tag, 32'd1, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 7 + 16'h1000);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state
        @(negedge clk);
        check("R10 busy", {31'd0, busy}, 32'd0);
        check("R10 req", {31'd0, mem_req}, 32'd0);
        check("R10 err", {31'd0, mode_err}, 32'd0);
        for (int r = 0; r < 8; r++) read_reg(3'(r), 16'h0, "R10 reg");

        // R1: every register including the spare reads back
        for (int r = 1; r < 8; r++) reg_write(3'(r), 16'(16'h1100 * r + 16'h0033));
        for (int r = 1; r < 8; r++) read_reg(3'(r), 16'(16'h1100 * r + 16'h0033), "R1 readback");

        // R2/R3/R4: copy with a non-zero source high half, ready always high
        setup(32'h0001_0040, 32'h0000_0200, 32'd5);
        predict(32'h0001_0040, 32'h0000_0200, 5);
        reg_write(3'd0, 16'h4009);
        wait_idle();
        check("R2 first read", first_rd, 32'h0001_0040);
        check("R2 first write", first_wr, 32'h0000_0200);
        compare_mem("R3 copy");

        // R9 with stalls, R8 writes during the copy are dropped
        stall_mode = 1'b1;
        setup(32'h0000_0300, 32'h0000_0400, 32'd9);
        predict(32'h0000_0300, 32'h0000_0400, 9);
        reg_write(3'd0, 16'h4009);
        reg_write(3'd1, 16'hdead);
        reg_write(3'd0, 16'h4009);
        reg_write(3'd0, 16'h7777);
        wait_idle();
        stall_mode = 1'b0;
        compare_mem("R9 stalled copy");
        read_reg(3'd1, 16'h0300, "R8 src low kept");
        read_reg(3'd0, 16'h4009, "R8 mode kept");
        check("R8 no error", {31'd0, mode_err}, 32'd0);

        // R5: inert code
        reg_write(3'd0, 16'h0200);
        @(negedge clk);
        check("R5 no busy", {31'd0, busy}, 32'd0);
        check("R5 no error", {31'd0, mode_err}, 32'd0);
        read_reg(3'd0, 16'h0200, "R5 stored");

        // R7: zero count
        reg_write(3'd3, 16'h0); reg_write(3'd6, 16'h0);
        reg_write(3'd0, 16'h4009);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R7 no busy", {31'd0, busy}, 32'd0);
            check("R7 no req", {31'd0, mem_req}, 32'd0);
        end

        // R6: unknown code sets a sticky flag
        reg_write(3'd0, 16'h1234);
        @(negedge clk);
        check("R6 err set", {31'd0, mode_err}, 32'd1);
        check("R6 no busy", {31'd0, busy}, 32'd0);
        read_reg(3'd0, 16'h1234, "R6 stored");
        reg_write(3'd0, 16'h0200);
        @(negedge clk);
        check("R6 err sticky", {31'd0, mode_err}, 32'd1);

        // R4: overlapping forward copy replicates the first word
        setup(32'h0000_0500, 32'h0000_0501, 32'd6);
        predict(32'h0000_0500, 32'h0000_0501, 6);
        reg_write(3'd0, 16'h4009);
        wait_idle();
        compare_mem("R4 overlap copy");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule